// File: doc/BRIEF.md
# Codec Channel Power Sequencer

This block decides when a voice codec channel is powered and when its serial transmit output may drive the line. The channel comes out of reset powered down. It wakes on the first frame-sync rising edge, from either direction, that arrives while the shared master-clock/power-down pin is not held at a static high level. It goes back down when that pin stays high long enough to count as a static level, or when no frame-sync edge has been seen for a programmable number of master-clock cycles. The default of 4096 cycles is about 2 ms at 2.048 MHz.

The shared pin can carry a receive master clock, so a high level alone is not a power-down request. It becomes one only after the pin has been sampled high on a parameterised number of consecutive cycles. After each wake-up, the transmit output qualifier stays low until the second transmit frame-sync edge has been seen. This keeps stale data off the bus during the first frame. Both outputs are registered and both clear at reset. A power-down clears the output qualifier in the same cycle, even in the middle of a byte, and the transmit edge count starts again from zero.

The frame syncs and the shared pin are sampled on the master clock. A sync counts only on a rising edge, so a long frame sync that stays high counts once.

Top module: `codec_pwr_seq`

## Requirements
- R1: During and after reset, until a wake-up occurs, `pwr_en` and `tx_oe_ok` are both 0.
- R2: While powered down, a rising edge on `fs_tx` or `fs_rx` (high now, low in the previous cycle) with the pin not classified static-high sets `pwr_en` to 1 from the next clock edge.
- R3: The pin is static-high once it has been sampled high on `PDN_HOLD` consecutive edges. The edge after that drops `pwr_en` and `tx_oe_ok` to 0.
- R4: A pin that toggles with high runs shorter than `PDN_HOLD` cycles neither powers the channel down nor blocks a wake-up.
- R5: While the pin is static-high, frame-sync edges do not power the channel up.
- R6: If no frame-sync rising edge is seen for `IDLE_CYC` consecutive cycles after the last one, the following edge drops `pwr_en`. Any new sync rising edge restarts the count.
- R7: `tx_oe_ok` rises at the edge that samples the second `fs_tx` rising edge since wake-up. A waking `fs_tx` edge counts as the first one. `fs_rx` edges do not count.
- R8: `tx_oe_ok` is never 1 while `pwr_en` is 0. After any power-down, two new `fs_tx` edges are needed again.
- R9: A frame sync held high for several cycles counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pdn_pin | input | 1 | Shared receive-clock / power-down pin, sampled |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| pwr_en | output | 1 | Channel power enable |
| tx_oe_ok | output | 1 | Qualifier allowing the transmit data output to drive |

## Verification
The bench builds the block with `PDN_HOLD` = 8 and `IDLE_CYC` = 64. With these values, both the static-high decision and the inactivity timeout are reached, and passed, within a few dozen cycles. This lets a short run cover a pin that toggles just below the hold length and one held just beyond it. It also covers a sync stream that keeps the channel alive, followed by one that stops and times out. A power-down while the output qualifier is set, followed by a second wake-up, exercises the restart of the transmit edge count.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef enum logic {
    PS_DOWN = 1'b0,
    PS_UP   = 1'b1
  } pwr_state_t;

  localparam int TX_SYNC_NEED = 2;
endpackage

// File: rtl/cpd_pin_classifier.sv
module cpd_pin_classifier #(
  parameter int PDN_HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic static_hi
);
  localparam int CW = $clog2(PDN_HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(PDN_HOLD);

  logic [CW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
    end else if (!pin) begin
      hi_run <= '0;
    end else if (hi_run != HOLD_V) begin
      hi_run <= hi_run + 1'b1;
    end
  end

  assign static_hi = (hi_run == HOLD_V);

  // R4
  hold_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    static_hi |-> $past(pin));
endmodule

// File: rtl/cpd_sync_watch.sv
module cpd_sync_watch #(
  parameter int IDLE_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_tx,
  input  logic fs_rx,
  output logic tx_edge,
  output logic any_edge,
  output logic idle_out
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] IDLE_V = IW'(IDLE_CYC);

  logic fs_tx_q, fs_rx_q;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_tx_q <= 1'b0;
      fs_rx_q <= 1'b0;
    end else begin
      fs_tx_q <= fs_tx;
      fs_rx_q <= fs_rx;
    end
  end

  assign tx_edge  = fs_tx & ~fs_tx_q;
  assign any_edge = tx_edge | (fs_rx & ~fs_rx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
    end else if (any_edge) begin
      idle_cnt <= '0;
    end else if (idle_cnt != IDLE_V) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign idle_out = (idle_cnt == IDLE_V);

  // R6
  edge_restarts_timer_chk: assert property (@(posedge clk) disable iff (rst)
    any_edge |=> !idle_out);

  // R9
  edge_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_edge |=> !tx_edge);
endmodule

// File: rtl/cpd_power_fsm.sv
module cpd_power_fsm
  import codec_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic static_hi,
  input  logic idle_out,
  input  logic tx_edge,
  input  logic any_edge,
  output logic pwr_en,
  output logic tx_oe_ok
);
  pwr_state_t state, state_nx;
  logic [1:0] tx_cnt, tx_cnt_nx;

  always_comb begin
    state_nx  = state;
    tx_cnt_nx = tx_cnt;
    if (state == PS_UP) begin
      if (static_hi || idle_out) begin
        state_nx  = PS_DOWN;
        tx_cnt_nx = '0;
      end else if (tx_edge && tx_cnt != 2'(TX_SYNC_NEED)) begin
        tx_cnt_nx = tx_cnt + 1'b1;
      end
    end else begin
      tx_cnt_nx = '0;
      if (any_edge && !static_hi) begin
        state_nx  = PS_UP;
        tx_cnt_nx = tx_edge ? 2'd1 : 2'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PS_DOWN;
      tx_cnt   <= '0;
      pwr_en   <= 1'b0;
      tx_oe_ok <= 1'b0;
    end else begin
      state    <= state_nx;
      tx_cnt   <= tx_cnt_nx;
      pwr_en   <= (state_nx == PS_UP);
      tx_oe_ok <= (state_nx == PS_UP) && (tx_cnt_nx == 2'(TX_SYNC_NEED));
    end
  end

  // R8
  oe_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    tx_oe_ok |-> pwr_en);

  // R5
  no_wake_when_static_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && static_hi) |=> !pwr_en);

  // R3
  static_forces_down_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && static_hi) |=> (!pwr_en && !tx_oe_ok));

  // R7
  oe_rise_on_tx_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe_ok) |-> $past(tx_edge));
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq #(
  parameter int PDN_HOLD = 16,
  parameter int IDLE_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic pdn_pin,
  input  logic fs_tx,
  input  logic fs_rx,
  output logic pwr_en,
  output logic tx_oe_ok
);
  logic static_hi, tx_edge, any_edge, idle_out;

  cpd_pin_classifier #(.PDN_HOLD(PDN_HOLD)) u_pin (
    .clk(clk), .rst(rst), .pin(pdn_pin), .static_hi(static_hi)
  );

  cpd_sync_watch #(.IDLE_CYC(IDLE_CYC)) u_sync (
    .clk(clk), .rst(rst), .fs_tx(fs_tx), .fs_rx(fs_rx),
    .tx_edge(tx_edge), .any_edge(any_edge), .idle_out(idle_out)
  );

  cpd_power_fsm u_fsm (
    .clk(clk), .rst(rst), .static_hi(static_hi), .idle_out(idle_out),
    .tx_edge(tx_edge), .any_edge(any_edge),
    .pwr_en(pwr_en), .tx_oe_ok(tx_oe_ok)
  );

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (!pwr_en && !tx_oe_ok));
endmodule

// File: tb/codec_pwr_seq_tb.sv
module codec_pwr_seq_tb;
  localparam int H = 8;
  localparam int T = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn_pin = 1'b0, fs_tx = 1'b0, fs_rx = 1'b0;
  logic pwr_en, tx_oe_ok;

  always #2 clk = ~clk;

  codec_pwr_seq #(.PDN_HOLD(H), .IDLE_CYC(T)) u_dut (
    .clk(clk), .rst(rst), .pdn_pin(pdn_pin), .fs_tx(fs_tx), .fs_rx(fs_rx),
    .pwr_en(pwr_en), .tx_oe_ok(tx_oe_ok)
  );

  typedef struct {
    bit    pwr;
    bit    oe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model built from the requirements
  bit m_up, m_px, m_pr;
  int m_hirun, m_idle, m_tx;

  task automatic model_reset();
    m_up = 0; m_px = 0; m_pr = 0; m_hirun = 0; m_idle = 0; m_tx = 0;
  endtask

  task automatic step(input bit p, input bit x, input bit r, input string tag);
    bit st, to, ex, ea;
    exp_t e;
    @(negedge clk);
    rst = 1'b0; pdn_pin = p; fs_tx = x; fs_rx = r;
    st = (m_hirun >= H);
    to = (m_idle >= T);
    ex = x && !m_px;
    ea = ex || (r && !m_pr);
    if (m_up) begin
      if (st || to) begin m_up = 0; m_tx = 0; end
      else if (ex && m_tx < 2) m_tx++;
    end else if (ea && !st) begin
      m_up = 1; m_tx = ex ? 1 : 0;
    end
    m_hirun = p ? ((m_hirun < H) ? m_hirun + 1 : H) : 0;
    m_idle  = ea ? 0 : ((m_idle < T) ? m_idle + 1 : T);
    m_px = x; m_pr = r;
    e.pwr = m_up; e.oe = m_up && (m_tx >= 2); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic reset_step();
    exp_t e;
    @(negedge clk);
    rst = 1'b1; pdn_pin = 0; fs_tx = 0; fs_rx = 0;
    model_reset();
    e.pwr = 0; e.oe = 0; e.tag = "R1";
    exp_q.push_back(e);
  endtask

  task automatic idle_n(input int n, input bit p, input string tag);
    for (int i = 0; i < n; i++) step(p, 0, 0, tag);
  endtask

  // monitor: compares one expectation per clock edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pwr_en !== e.pwr || tx_oe_ok !== e.oe) begin
        errors++;
        $display("FAIL %s: pwr_en=%b tx_oe_ok=%b expected pwr_en=%b tx_oe_ok=%b",
                 e.tag, pwr_en, tx_oe_ok, e.pwr, e.oe);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) reset_step();
    idle_n(10, 0, "R1");
    // R2: receive sync wakes the channel
    step(0, 0, 1, "R2"); idle_n(5, 0, "R2");
    // R9: long transmit sync counts once; R7 needs a second one
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R9");
    idle_n(6, 0, "R9");
    step(0, 0, 1, "R7"); idle_n(4, 0, "R7");
    step(0, 1, 0, "R7"); idle_n(8, 0, "R7");
    // R4: pin toggling with short high runs, syncs keep channel alive
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < H - 1; i++) step(1, (i == 0), 0, "R4");
      for (int i = 0; i < 3; i++) step(0, 0, 0, "R4");
    end
    // R3: pin held high past the hold length, mid-stream
    for (int i = 0; i < H + 4; i++) step(1, (i == 3), 0, "R3");
    // R5: syncs while static-high do nothing
    for (int i = 0; i < 20; i++) step(1, (i % 5 == 0), (i % 7 == 0), "R5");
    // R8: re-wake by transmit sync, count restarts
    idle_n(2, 0, "R8");
    step(0, 1, 0, "R8"); idle_n(6, 0, "R8");
    step(0, 1, 0, "R8"); idle_n(6, 0, "R8");
    // R6: syncs every 50 cycles keep it up, then silence times out
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 1, "R6"); idle_n(49, 0, "R6");
    end
    idle_n(T + 10, 0, "R6");
    // R4: wake while the pin is toggling
    for (int i = 0; i < 12; i++) step(i[1], (i == 5), 0, "R4");
    idle_n(4, 0, "R4");
    step(0, 1, 0, "R7"); idle_n(4, 0, "R7");
    // R1: reset while powered
    reset_step(); idle_n(5, 0, "R1");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule